// File: doc/BRIEF.md
# Per-Slot Control Bit Serializer

This block drives one serial control line that, once per frame, carries a single flag bit for every output slot of a time-division switch. A slot is one stream within one channel period. The flags are held in an external connection store. The block generates the read address and sends the returned bit out, one bit per bit clock.

Each flag is sent one whole channel period ahead of the data slot it describes, so that external circuitry has time to act on it. Within a channel period there are as many bit times as there are streams. The flags in that period belong to the following channel and go out in stream order, lowest stream first. The channel-0 flags go out during the last channel of the previous frame.

The frame position comes from the same frame-sync and bit clock that time the switch's data outputs. The block looks ahead by the store's read latency, so that the returned bit lands on the right bit boundary.

Top module: `ctl_bit_serializer`

## Requirements
- R1: A frame is NST*NCH bit times. When `fsync_i` is high in a cycle, the next cycle is bit time 0. Without `fsync_i`, the bit time after the last one is 0 again.
- R2: During bit time t, `ctl_o` carries the flag of stream t mod NST in channel (t div NST)+1.
- R3: During the last channel period of a frame (channel NCH-1), `ctl_o` carries the flags of channel 0 of the next frame.
- R4: Within one channel period the flags go out in ascending stream order: stream 0 in the first bit time of the period, stream NST-1 in the last.
- R5: `flag_addr_o` carries the stream number in its upper log2(NST) bits and the channel number in its lower log2(NCH) bits. The store returns the addressed flag on `flag_i` RD_LAT clock edges after it samples the address (RD_LAT=1: one registered read stage).
- R6: In a frame that follows a full frame with no re-synchronisation, each slot's flag appears on `ctl_o` exactly once.
- R7: While `rst_ni` is low, `ctl_o` is 0 and `flag_addr_o` points at the slot for bit time RD_LAT of the frame that begins at the first clock edge after release. With the default parameters that is stream 1, channel 1, so `flag_addr_o` = 0x21. The first cycle after release is bit time 0. Only the first RD_LAT bit times after release may carry stale flags.
- R8: When `fsync_i` arrives before the natural end of a frame, the frame restarts. From bit time RD_LAT of the new frame onward, `ctl_o` follows R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock shared with the switch outputs |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync; high in the cycle before bit time 0 |
| flag_addr_o | output | log2(NST)+log2(NCH) | Read address into the flag store, {stream, channel} |
| flag_i | input | 1 | Flag bit returned by the store |
| ctl_o | output | 1 | Serial per-slot control output |

## Verification
The assertions check the frame counter on every cycle: the restart after a sync, the single step forward and the wrap at the end of a frame. They also check that the read address steps through the streams one per cycle and moves to the next channel, modulo NCH, each time the stream field wraps. Only the bench scenarios can show that the bit reaching `ctl_o` is the right slot's flag at the right bit time. This needs a modelled store, so the bench covers the one-channel lead, the channel-0 wrap into the previous frame, the once-per-frame coverage, the stale bits after reset and after a re-synchronisation, and free running without a sync.

// File: rtl/cbs_pkg.sv
package cbs_pkg;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/cbs_frame_ctr.sv
module cbs_frame_ctr #(
   parameter int unsigned NST = 8,
   parameter int unsigned NCH = 32,
   localparam int unsigned FRAME = NST * NCH,
   localparam int unsigned POS_W = $clog2(FRAME)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             fsync_i,
   output logic [POS_W-1:0] pos_next_o
);

   localparam logic [POS_W-1:0] LAST = POS_W'(FRAME - 1);

   logic [POS_W-1:0] pos_q;

   always_comb begin
      if (fsync_i || pos_q == LAST) pos_next_o = '0;
      else                          pos_next_o = pos_q + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pos_q <= LAST;
      else         pos_q <= pos_next_o;
   end

   AST_FS_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fsync_i |=> pos_q == '0); // R1

   AST_FRAME_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fsync_i && pos_q == LAST) |=> pos_q == '0); // R1

   AST_POS_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fsync_i && pos_q != LAST) |=> pos_q == POS_W'($past(pos_q) + 1'b1)); // R1

endmodule

// File: rtl/cbs_lookahead.sv
module cbs_lookahead #(
   parameter int unsigned NST    = 8,
   parameter int unsigned NCH    = 32,
   parameter int unsigned RD_LAT = 1,
   localparam int unsigned FRAME = NST * NCH,
   localparam int unsigned POS_W = $clog2(FRAME),
   localparam int unsigned ST_W  = $clog2(NST),
   localparam int unsigned CH_W  = POS_W - ST_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             fsync_i,
   input  logic [POS_W-1:0] pos_next_i,
   output logic [ST_W-1:0]  stream_o,
   output logic [CH_W-1:0]  chan_o
);

   localparam logic [POS_W:0]  LAT_V   = (POS_W + 1)'(RD_LAT);
   localparam logic [POS_W:0]  FRAME_V = (POS_W + 1)'(FRAME);
   localparam logic [CH_W-1:0] CH_LAST = CH_W'(NCH - 1);

   logic [POS_W:0]   sum;
   logic [POS_W-1:0] la;
   logic [CH_W-1:0]  chan_cur;

   assign sum = {1'b0, pos_next_i} + LAT_V;

   generate
      if (cbs_pkg::is_pow2(FRAME)) begin : g_wrap_trunc
         assign la = sum[POS_W-1:0];
      end else begin : g_wrap_cmp
         logic [POS_W:0] sum_w;
         assign sum_w = (sum >= FRAME_V) ? sum - FRAME_V : sum;
         assign la    = sum_w[POS_W-1:0];
      end
   endgenerate

   assign stream_o = la[ST_W-1:0];
   assign chan_cur = la[POS_W-1:ST_W];
   assign chan_o   = (chan_cur == CH_LAST) ? '0 : chan_cur + 1'b1;

   AST_STREAM_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fsync_i ##1 !fsync_i) |-> stream_o == ST_W'($past(stream_o) + 1'b1)); // R4

   AST_CHAN_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fsync_i ##1 (!fsync_i && stream_o == '0)) |->
         chan_o == (($past(chan_o) == CH_LAST) ? '0 : CH_W'($past(chan_o) + 1'b1))); // R3

   AST_CHAN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!fsync_i ##1 (!fsync_i && stream_o != '0)) |-> $stable(chan_o)); // R2

endmodule

// File: rtl/ctl_bit_serializer.sv
module ctl_bit_serializer #(
   parameter int unsigned NST    = 8,
   parameter int unsigned NCH    = 32,
   parameter int unsigned RD_LAT = 1,
   localparam int unsigned FRAME = NST * NCH,
   localparam int unsigned POS_W = $clog2(FRAME),
   localparam int unsigned ST_W  = $clog2(NST),
   localparam int unsigned CH_W  = POS_W - ST_W
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             fsync_i,
   output logic [POS_W-1:0] flag_addr_o,
   input  logic             flag_i,
   output logic             ctl_o
);

   generate
      if (!cbs_pkg::is_pow2(NST) || NST < 2) begin : g_bad_nst
         $error("NST must be a power of two and at least 2");
      end
      if (NCH < 2) begin : g_bad_nch
         $error("NCH must be at least 2");
      end
      if (RD_LAT >= FRAME) begin : g_bad_lat
         $error("RD_LAT must be shorter than a frame");
      end
   endgenerate

   logic [POS_W-1:0] pos_next;
   logic [ST_W-1:0]  stream;
   logic [CH_W-1:0]  chan;
   logic             ctl_q;

   cbs_frame_ctr #(.NST(NST), .NCH(NCH)) u_ctr (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .fsync_i    (fsync_i),
      .pos_next_o (pos_next)
   );

   cbs_lookahead #(.NST(NST), .NCH(NCH), .RD_LAT(RD_LAT)) u_la (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .fsync_i    (fsync_i),
      .pos_next_i (pos_next),
      .stream_o   (stream),
      .chan_o     (chan)
   );

   assign flag_addr_o = {stream, chan};

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctl_q <= 1'b0;
      else         ctl_q <= flag_i;
   end

   assign ctl_o = ctl_q;

   AST_ADDR_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$isunknown(flag_addr_o)); // R5

endmodule

// File: tb/ctl_bit_serializer_bench.sv
module ctl_bit_serializer_bench;

   localparam int NST = 8;
   localparam int NCH = 32;
   localparam int FRAME = NST * NCH;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fs = 1'b0;
   logic [7:0] addr;
   logic       mem_q = 1'b0;
   logic       ctl;

   logic flags [NST][NCH];

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   ctl_bit_serializer u_ctl_bit_serializer (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .fsync_i     (fs),
      .flag_addr_o (addr),
      .flag_i      (mem_q),
      .ctl_o       (ctl)
   );

   // store model: {stream[7:5], channel[4:0]}, one registered read stage (R5)
   always @(posedge clk) mem_q <= flags[addr[7:5]][addr[4:0]];

   // bit time t, stream t mod 8, channel (t/8)+1 mod 32
   localparam int TV [8][3] = '{
      '{0,   0, 1},
      '{7,   7, 1},
      '{64,  0, 9},
      '{71,  7, 9},
      '{72,  0, 10},
      '{131, 3, 17},
      '{248, 0, 0},
      '{255, 7, 0}
   };

   function automatic logic exp_flag(input int t);
      return flags[t % NST][((t / NST) + 1) % NCH];
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic check_int(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_all(input logic v);
      for (int s = 0; s < NST; s++)
         for (int c = 0; c < NCH; c++) flags[s][c] = v;
   endtask

   task automatic set_random();
      for (int s = 0; s < NST; s++)
         for (int c = 0; c < NCH; c++) flags[s][c] = 1'($urandom_range(0, 1));
   endtask

   // entered at the negedge inside bit time 0; leaves at bit time 0 of next frame
   task automatic run_frame(input bit do_chk, input int from, input bit use_fs,
                            input string req);
      for (int t = 0; t < FRAME; t++) begin
         fs = use_fs && (t == FRAME - 1);
         if (do_chk && t >= from) check(req, ctl, exp_flag(t));
         @(negedge clk);
      end
      fs = 1'b0;
   endtask

   initial begin
      #(10 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      set_random();
      repeat (3) @(negedge clk);
      // R7: reset state
      check("R7", ctl, 1'b0);
      check_int("R7", int'(addr), 8'h21);
      rst_n = 1'b1;
      @(negedge clk);
      // first frame after release, no sync: stale only for RD_LAT bit times
      run_frame(1'b1, 1, 1'b0, "R7");
      // free running without sync (R1)
      run_frame(1'b1, 0, 1'b0, "R1");

      // table walk: one-hot flag at a chosen slot
      for (int v = 0; v < 8; v++) begin
         int ones;
         string req;
         req = (TV[v][2] == 0) ? "R3" : ((TV[v][1] == 0) ? "R4" : "R2");
         set_all(1'b0);
         flags[TV[v][1]][TV[v][2]] = 1'b1;
         run_frame(1'b0, 0, 1'b1, req);
         ones = 0;
         for (int t = 0; t < FRAME; t++) begin
            fs = (t == FRAME - 1);
            if (ctl === 1'b1) ones++;
            if (t == TV[v][0]) check(req, ctl, 1'b1);
            @(negedge clk);
         end
         fs = 1'b0;
         check_int("R6", ones, 1);
      end

      // R6: all ones means every bit time is high
      set_all(1'b1);
      run_frame(1'b0, 0, 1'b1, "R6");
      run_frame(1'b1, 0, 1'b1, "R6");

      // random patterns, every bit time checked (R2)
      for (int p = 0; p < 4; p++) begin
         set_random();
         run_frame(1'b0, 0, 1'b1, "R2");
         run_frame(1'b1, 0, 1'b1, "R2");
      end

      // R8: early sync at bit time 100
      set_random();
      for (int t = 0; t <= 100; t++) begin
         fs = (t == 100);
         @(negedge clk);
      end
      fs = 1'b0;
      run_frame(1'b1, 1, 1'b1, "R8");
      run_frame(1'b1, 0, 1'b1, "R8");

      // R7: reset in mid-frame
      repeat (37) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R7", ctl, 1'b0);
      check_int("R7", int'(addr), 8'h21);
      rst_n = 1'b1;
      @(negedge clk);
      run_frame(1'b1, 1, 1'b1, "R7");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule